// File: doc/BRIEF.md
# Two-Line Interrupt Router with Per-Line Priority Encoding

This block collects up to 64 level-sensitive request lines and steers each one to one of two processor inputs: an ordinary interrupt line (`irq_o`) and a fast interrupt line (`fiq_o`). Each source has its own mask bit and its own steering bit. A source that is raised, unmasked and steered to a line shows up in that line's status word. The line itself goes high one clock later.

For every line the block also reports which active source wins. By default the highest-numbered active source wins. When the error-override bit is set, one fixed error source (parameter `ERR_SRC`, default 61) wins over all others whenever it is active on that line.

Software uses a simple 32-bit word port with a write strobe, a byte address and combinational read data. Sources 0 to 31 sit in the register window at 0x00 to 0x10. Sources 32 to 63 sit in a second window 0x20 higher. Inside each window the order is: raw request, mask, steering, ordinary-line status, fast-line status. The winner index of the ordinary line is at 0x18, the winner index of the fast line is at 0x1C, and the override bit is at 0x34.

Top module: `icu_dual`

## Requirements
- R1: After reset the mask words (0x04, 0x24), the steering words (0x08, 0x28) and the override bit (0x34) read 0, and both `irq_o` and `fiq_o` are low.
- R2: Raw request words 0x00 (sources 31..0) and 0x20 (sources 63..32) show `src_i` as it was sampled at the previous rising clock edge.
- R3: A write to 0x04/0x24 (mask, 1 = enabled) or to 0x08/0x28 (steering, 1 = fast line) stores the full word, and that word reads back from the following cycle. A write to 0x34 stores only bit 0, and bits 31..1 of 0x34 read 0.
- R4: The ordinary-line status at 0x0C/0x2C reads raw AND mask AND NOT steering.
- R5: The fast-line status at 0x10/0x30 reads raw AND mask AND steering.
- R6: `irq_o` equals the OR of all 64 ordinary-line status bits one cycle earlier. `fiq_o` equals the OR of all fast-line status bits one cycle earlier.
- R7: The index words 0x18 (ordinary line) and 0x1C (fast line) hold the winning source number in bits 5..0 and a valid flag in bit 31. With the override bit clear, the winner is the highest-numbered active source. When no source is active on the line, the word reads 0.
- R8: With the override bit set and source `ERR_SRC` active on a line, that line's index word reads `ERR_SRC` with the valid flag set, even if higher-numbered sources are also active.
- R9: Writes to the raw, status and index words, to 0x14, to unmapped offsets and to addresses with bits 1..0 not zero change nothing. 0x14, unmapped offsets and misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Level-sensitive request lines |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 6 | Byte address of the register port |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Registered ordinary interrupt line |
| fiq_o | output | 1 | Registered fast interrupt line |

## Verification
A wrong mask or steering bit shows up in the status words in the same cycle it is read back. It reaches `irq_o` or `fiq_o` one clock later, and only if the affected source is raised at the time. A faulty priority choice shows only at 0x18/0x1C, and only while at least two sources are active on the same line. For that reason the stimulus keeps many sources active at once and drives the error source together with a higher-numbered neighbour. The bench model compares every readable word and both lines on every cycle. A divergence is therefore reported in the cycle it first becomes visible at the ports.

// File: rtl/icu_pkg.sv
`timescale 1ns/1ps
package icu_pkg;
  localparam int WORD_W = 32;

  // word slot inside one 0x20-byte bank window
  typedef enum logic [2:0] {
    SLOT_RAW  = 3'd0,
    SLOT_MASK = 3'd1,
    SLOT_STEER = 3'd2,
    SLOT_NSTAT = 3'd3,
    SLOT_FSTAT = 3'd4,
    SLOT_X5   = 3'd5,
    SLOT_X6   = 3'd6,
    SLOT_X7   = 3'd7
  } slot_e;

  // bank 0 extra slots: 5 reserved (reads 0), 6 ordinary winner, 7 fast winner
  // bank 1 extra slot 5: error override bit
  localparam int OVR_BANK = 1;
  localparam int VALID_BIT = 31;
endpackage

// File: rtl/icu_regfile.sv
`timescale 1ns/1ps
module icu_regfile
  import icu_pkg::*;
#(
  parameter int NBANK = 2,
  localparam int NSRC = NBANK * WORD_W,
  localparam int ADW = $clog2(NBANK) + 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [ADW-1:0]  addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] steer_q,
  output logic            ovr_q
);
  localparam int BW = $clog2(NBANK);

  logic              aligned;
  logic [BW-1:0]     bank_f;
  slot_e             slot_f;

  assign aligned = (addr[1:0] == 2'b00);
  assign bank_f  = addr[ADW-1:5];
  assign slot_f  = slot_e'(addr[4:2]);

  function automatic logic hit(input logic we, input logic al, input logic [BW-1:0] bk,
                               input slot_e sl, input int want_bank, input slot_e want_slot);
    return we && al && (bk == BW'(want_bank)) && (sl == want_slot);
  endfunction

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic wr_mask, wr_steer;
    assign wr_mask  = hit(wr_en, aligned, bank_f, slot_f, b, SLOT_MASK);
    assign wr_steer = hit(wr_en, aligned, bank_f, slot_f, b, SLOT_STEER);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[b*WORD_W +: WORD_W]  <= '0;
        steer_q[b*WORD_W +: WORD_W] <= '0;
      end else begin
        if (wr_mask)  mask_q[b*WORD_W +: WORD_W]  <= wdata;
        if (wr_steer) steer_q[b*WORD_W +: WORD_W] <= wdata;
      end
    end
  end

  logic wr_ovr;
  assign wr_ovr = hit(wr_en, aligned, bank_f, slot_f, OVR_BANK, SLOT_X5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= 1'b0;
    else if (wr_ovr) ovr_q <= wdata[0];
  end
endmodule

// File: rtl/icu_route.sv
`timescale 1ns/1ps
module icu_route #(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] steer,
  output logic [NSRC-1:0] nstat,
  output logic [NSRC-1:0] fstat,
  output logic            nline_q,
  output logic            fline_q
);
  function automatic logic [NSRC-1:0] gate(input logic [NSRC-1:0] r, input logic [NSRC-1:0] m,
                                           input logic [NSRC-1:0] s, input logic to_fast);
    return r & m & (to_fast ? s : ~s);
  endfunction

  assign nstat = gate(raw, mask, steer, 1'b0);
  assign fstat = gate(raw, mask, steer, 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nline_q <= 1'b0;
      fline_q <= 1'b0;
    end else begin
      nline_q <= |nstat;
      fline_q <= |fstat;
    end
  end
endmodule

// File: rtl/icu_prio.sv
`timescale 1ns/1ps
module icu_prio #(
  parameter int NSRC = 64,
  parameter int ERR_SRC = 61,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic            [NSRC-1:0] vec,
  input  logic                       ovr,
  output logic            [IDXW-1:0] idx,
  output logic                       vld
);
  // returns {valid, index}; highest set bit wins unless override picks ERR_SRC
  function automatic logic [IDXW:0] pick(input logic [NSRC-1:0] v, input logic o);
    logic [IDXW:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++)
      if (v[i]) r = {1'b1, IDXW'(i)};
    if (o && v[ERR_SRC]) r = {1'b1, IDXW'(ERR_SRC)};
    return r;
  endfunction

  assign {vld, idx} = pick(vec, ovr);
endmodule

// File: rtl/icu_dual.sv
`timescale 1ns/1ps
module icu_dual
  import icu_pkg::*;
#(
  parameter int NBANK = 2,
  parameter int ERR_SRC = 61,
  localparam int NSRC = NBANK * WORD_W,
  localparam int ADW = $clog2(NBANK) + 5,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en_i,
  input  logic [ADW-1:0]    addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int BW = $clog2(NBANK);

  // named internal events for the checker
  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] mask_q, steer_q;
  logic            ovr_q;
  logic [NSRC-1:0] nstat, fstat;
  logic [IDXW-1:0] n_idx, f_idx;
  logic            n_vld, f_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= src_i;
  end

  icu_regfile #(.NBANK(NBANK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
    .mask_q(mask_q), .steer_q(steer_q), .ovr_q(ovr_q)
  );

  icu_route #(.NSRC(NSRC)) u_route (
    .clk(clk), .rst_n(rst_n), .raw(raw_q), .mask(mask_q), .steer(steer_q),
    .nstat(nstat), .fstat(fstat), .nline_q(irq_o), .fline_q(fiq_o)
  );

  icu_prio #(.NSRC(NSRC), .ERR_SRC(ERR_SRC)) u_prio_n (
    .vec(nstat), .ovr(ovr_q), .idx(n_idx), .vld(n_vld)
  );

  icu_prio #(.NSRC(NSRC), .ERR_SRC(ERR_SRC)) u_prio_f (
    .vec(fstat), .ovr(ovr_q), .idx(f_idx), .vld(f_vld)
  );

  function automatic logic [WORD_W-1:0] win_word(input logic v, input logic [IDXW-1:0] i);
    logic [WORD_W-1:0] w;
    w = '0;
    w[IDXW-1:0] = i;
    w[VALID_BIT] = v;
    return w;
  endfunction

  logic [BW-1:0] bank_f;
  slot_e         slot_f;
  assign bank_f = addr_i[ADW-1:5];
  assign slot_f = slot_e'(addr_i[4:2]);

  always_comb begin
    rdata_o = '0;
    if (addr_i[1:0] == 2'b00) begin
      for (int b = 0; b < NBANK; b++) begin
        if (bank_f == BW'(b)) begin
          unique case (slot_f)
            SLOT_RAW:   rdata_o = raw_q[b*WORD_W +: WORD_W];
            SLOT_MASK:  rdata_o = mask_q[b*WORD_W +: WORD_W];
            SLOT_STEER: rdata_o = steer_q[b*WORD_W +: WORD_W];
            SLOT_NSTAT: rdata_o = nstat[b*WORD_W +: WORD_W];
            SLOT_FSTAT: rdata_o = fstat[b*WORD_W +: WORD_W];
            SLOT_X5:    if (b == OVR_BANK) rdata_o = {{(WORD_W-1){1'b0}}, ovr_q};
            SLOT_X6:    if (b == 0) rdata_o = win_word(n_vld, n_idx);
            SLOT_X7:    if (b == 0) rdata_o = win_word(f_vld, f_idx);
            default:    rdata_o = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/icu_dual_chk.sv
`timescale 1ns/1ps
module icu_dual_chk #(
  parameter int NSRC = 64,
  parameter int ERR_SRC = 61,
  parameter int IDXW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic [NSRC-1:0] raw_q,
  input logic [NSRC-1:0] nstat,
  input logic [NSRC-1:0] fstat,
  input logic            ovr_q,
  input logic [IDXW-1:0] n_idx,
  input logic            n_vld,
  input logic [IDXW-1:0] f_idx,
  input logic            f_vld,
  input logic            irq_o,
  input logic            fiq_o
);
  a_r1_lines_low_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq_o && !fiq_o));

  a_r2_raw_tracks_src: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (raw_q == $past(src_i)));

  a_r4_r5_lines_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (nstat & fstat) == '0);

  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_o == $past(|nstat)));

  a_r6_fiq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (fiq_o == $past(|fstat)));

  a_r7_valid_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (n_vld == (nstat != '0)) && (f_vld == (fstat != '0)));

  a_r7_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
    n_vld |-> nstat[n_idx]);

  a_r8_error_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && fstat[ERR_SRC]) |-> (f_vld && f_idx == IDXW'(ERR_SRC)));
endmodule

bind icu_dual icu_dual_chk #(.NSRC(NSRC), .ERR_SRC(ERR_SRC), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .raw_q(raw_q), .nstat(nstat), .fstat(fstat),
  .ovr_q(ovr_q), .n_idx(n_idx), .n_vld(n_vld), .f_idx(f_idx), .f_vld(f_vld),
  .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/test_icu_dual.sv
`timescale 1ns/1ps
module test_icu_dual;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_on  = 0;

  always #2 clk = ~clk;

  icu_dual i_icu_dual (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  // behavioural reference model
  logic [63:0] m_raw = '0, m_en = '0, m_sel = '0;
  bit          m_ovr = 0, m_irq = 0, m_fiq = 0;

  function automatic bit any_set(input logic [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] winner(input logic [63:0] v, input bit ovr);
    if (ovr && v[61]) return 32'h8000_0000 | 32'd61;
    for (int i = 63; i >= 0; i--) if (v[i]) return 32'h8000_0000 | i;
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    logic [63:0] ns, fs;
    ns = m_raw & m_en & ~m_sel;
    fs = m_raw & m_en & m_sel;
    case (a)
      6'h00: return m_raw[31:0];
      6'h04: return m_en[31:0];
      6'h08: return m_sel[31:0];
      6'h0C: return ns[31:0];
      6'h10: return fs[31:0];
      6'h18: return winner(ns, m_ovr);
      6'h1C: return winner(fs, m_ovr);
      6'h20: return m_raw[63:32];
      6'h24: return m_en[63:32];
      6'h28: return m_sel[63:32];
      6'h2C: return ns[63:32];
      6'h30: return fs[63:32];
      6'h34: return {31'b0, m_ovr};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      6'h00, 6'h20: return "R2";
      6'h04, 6'h08, 6'h24, 6'h28, 6'h34: return "R3";
      6'h0C, 6'h2C: return "R4";
      6'h10, 6'h30: return "R5";
      6'h18, 6'h1C: return "R7";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw <= '0; m_en <= '0; m_sel <= '0; m_ovr <= 0; m_irq <= 0; m_fiq <= 0;
    end else begin
      m_irq <= any_set(m_raw & m_en & ~m_sel);
      m_fiq <= any_set(m_raw & m_en & m_sel);
      m_raw <= src;
      if (wr) begin
        case (addr)
          6'h04: m_en[31:0]   <= wdata;
          6'h24: m_en[63:32]  <= wdata;
          6'h08: m_sel[31:0]  <= wdata;
          6'h28: m_sel[63:32] <= wdata;
          6'h34: m_ovr        <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(tag_of(addr), rdata, exp_read(addr));
      check("R6", {31'b0, irq}, {31'b0, m_irq});
      check("R6", {31'b0, fiq}, {31'b0, m_fiq});
    end
  end

  task automatic wr_word(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    check(tag, rdata, exp);
  endtask

  localparam logic [5:0] LEGAL [13] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h18, 6'h1C,
                                        6'h20, 6'h24, 6'h28, 6'h2C, 6'h30, 6'h34};

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    rd_chk(6'h04, 32'h0, "R1");
    rd_chk(6'h08, 32'h0, "R1");
    rd_chk(6'h24, 32'h0, "R1");
    rd_chk(6'h28, 32'h0, "R1");
    rd_chk(6'h34, 32'h0, "R1");
    check("R1", {30'b0, irq, fiq}, 32'h0);
    cmp_on = 1;

    // R3: configuration
    wr_word(6'h04, 32'hFFFF_FFFF);
    wr_word(6'h24, 32'hFFFF_FFFF);
    wr_word(6'h08, 32'h0000_FFFF);
    wr_word(6'h28, 32'hF0F0_0000);
    wr_word(6'h34, 32'hFFFF_FFFF);
    rd_chk(6'h34, 32'h1, "R3");
    wr_word(6'h34, 32'h0);

    // mixed traffic, random writes everywhere (R2..R7, R9)
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      src = {$urandom, $urandom};
      if (k % 3 == 0) src = src & {$urandom, $urandom};
      wr = ($urandom % 6 == 0);
      wdata = $urandom;
      if ($urandom % 8 == 0) addr = 6'($urandom);
      else addr = LEGAL[$urandom % 13];
    end
    @(posedge clk); #1 wr = 0;

    // R7: empty line reads 0
    wr_word(6'h04, 32'hFFFF_FFFF);
    wr_word(6'h24, 32'hFFFF_FFFF);
    wr_word(6'h08, 32'h0);
    wr_word(6'h28, 32'hA000_0000); // sources 61 and 63 to fast line
    @(posedge clk); #1 src = '0;
    repeat (2) @(posedge clk);
    rd_chk(6'h18, 32'h0, "R7");
    rd_chk(6'h1C, 32'h0, "R7");

    // R7/R8: sources 61 and 63 on the fast line, 5 and 40 on the ordinary line
    @(posedge clk); #1 src = (64'd1 << 61) | (64'd1 << 63) | (64'd1 << 5) | (64'd1 << 40);
    repeat (2) @(posedge clk);
    rd_chk(6'h1C, 32'h8000_003F, "R7");
    rd_chk(6'h18, 32'h8000_0028, "R7");
    wr_word(6'h34, 32'h1);
    rd_chk(6'h1C, 32'h8000_003D, "R8");
    rd_chk(6'h18, 32'h8000_0028, "R8");
    check("R6", {31'b0, fiq}, 32'h1);

    // R9: writes to read-only, reserved and misaligned addresses
    wr_word(6'h14, 32'hFFFF_FFFF);
    rd_chk(6'h14, 32'h0, "R9");
    wr_word(6'h1C, 32'h0);
    rd_chk(6'h1C, 32'h8000_003D, "R9");
    wr_word(6'h05, 32'h0);
    rd_chk(6'h04, 32'hFFFF_FFFF, "R9");
    rd_chk(6'h25, 32'h0, "R9");

    repeat (3) @(posedge clk);
    cmp_on = 0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule